// File: doc/BRIEF.md
# Buffered Counter-Compare PWM Generator

This block drives one pulse-width-modulated output from a single system clock. A free-running up-counter runs from zero to a programmed terminal value and then restarts. The terminal value sets the switching period, and an equality compare against a programmed threshold sets where the pulse falls. The output rises at the start of every period. It drops on the clock where the counter reaches the threshold, and it stays low until the counter restarts.

Both programmed values go through a two-stage register pair. A write lands in a staging register. The staging register is copied into the working register only on the clock edge that starts a new period. A pulse therefore never changes partway through a period, and a write takes effect after a known delay of at most one period. A one-clock start strobe marks the first clock of every period, so a control loop can time its sampling to it.

The sequencing is a three-state machine. HOLD is entered on reset and keeps the output low. START_ON is taken at any period start whose new threshold is non-zero, and START_OFF at any period start whose new threshold is zero. HIGH moves to LOW through the FALL transition when the counter is about to equal the threshold. HIGH and LOW both take START_ON or START_OFF at the period boundary. The boundary check has priority over FALL.

Top module: `bpwm_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first clock after it is released, `pwm_out` and `frame_start` are both low. Reset loads a terminal value of all ones and a threshold of 0 into the staging and working registers.
- R2: With terminal value P in the working register, a period lasts P+1 clocks. `frame_start` is high in the first clock of each period only, so consecutive strobes are exactly P+1 clocks apart.
- R3: With working threshold M, where 0 < M <= P, `pwm_out` is high for counts 0 to M-1 (M clocks) and low for counts M to P.
- R4: A threshold of 0 keeps `pwm_out` low for the whole period, including its first clock.
- R5: A threshold greater than P keeps `pwm_out` high for the whole period, with no low clock at the wrap.
- R6: A threshold written while `cmp_wr` is high goes to staging only. It is copied into the working register on the edge that starts the next period. A write sampled on that same boundary edge is not copied until the boundary after it.
- R7: A terminal value written while `per_wr` is high follows the same staging rule as R6. The current period keeps its length.
- R8: A terminal value of 0 makes every clock a period start. `frame_start` stays high, and `pwm_out` is high on every clock if the threshold is non-zero and low if it is zero.
- R9: When several writes to the same value land within one period, only the last one is copied at the boundary.
- R10: The first period begins on the second clock after reset is released, with `frame_start` high. It uses the staging contents held at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| per_wr | input | 1 | Write strobe for the staged terminal count |
| per_in | input | CNT_W | Terminal count value (period minus one) |
| cmp_wr | input | 1 | Write strobe for the staged threshold |
| cmp_in | input | CNT_W | Threshold (on-time in clocks) |
| pwm_out | output | 1 | Modulated output |
| frame_start | output | 1 | One-clock strobe in the first clock of each period |

## Verification
The bench targets writes that land exactly on the boundary edge. A design that forwarded the input straight into the working register would change the current period one period early. It also drives thresholds of 0 and of exactly P+1. Getting these wrong shows up as a one-clock spike at the period start, or as a one-clock dip at the wrap. Terminal value 0 tests the case where every clock is a boundary. A design that let the compare win over the restart would leave the strobe or the output flickering. Bursts of several writes within one period, and a reset in the middle of a run, check the last-write-wins rule and the HOLD entry.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/bpwm_buffer.sv
// Staging register plus working register for one programmed value.
module bpwm_buffer #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         load,
    output logic [W-1:0] staged,
    output logic [W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= RST_VAL;
            active <= RST_VAL;
        end else begin
            // working copy takes the staged value held before this edge
            if (load) active <= staged;
            if (wr)   staged <= din;
        end
    end
endmodule

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || restart) count <= '0;
        else                count <= count + 1'b1;
    end
endmodule

// File: rtl/bpwm_phase.sv
module bpwm_phase
    import bpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         boundary,
    input  logic [W-1:0] next_cmp,
    input  logic [W-1:0] count,
    input  logic [W-1:0] act_cmp,
    output logic         pwm,
    output logic         strobe,
    output logic         holding
);
    localparam int XW = W + 1;

    phase_e state, nxt;
    logic   strobe_q;
    logic   fall_hit;
    phase_e start_sel;

    assign fall_hit  = ({1'b0, count} + XW'(1)) == {1'b0, act_cmp};
    assign start_sel = (next_cmp != '0) ? PH_HIGH : PH_LOW;

    always_comb begin
        nxt = state;
        unique case (state)
            PH_HOLD: nxt = start_sel;
            PH_HIGH: begin
                if (boundary)      nxt = start_sel;
                else if (fall_hit) nxt = PH_LOW;
            end
            PH_LOW: begin
                if (boundary) nxt = start_sel;
            end
            default: nxt = PH_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PH_HOLD;
        else     state <= nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= boundary;
    end

    assign pwm     = (state == PH_HIGH);
    assign holding = (state == PH_HOLD);
    assign strobe  = strobe_q;
endmodule

// File: rtl/bpwm_top.sv
module bpwm_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_in,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             pwm_out,
    output logic             frame_start
);
    localparam logic [CNT_W-1:0] PER_DEFAULT = '1;
    localparam logic [CNT_W-1:0] CMP_DEFAULT = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_staged, act_per;
    logic [CNT_W-1:0] cmp_staged, act_cmp;
    logic             holding;
    logic             boundary;

    assign boundary = holding || (cnt_q == act_per);

    bpwm_buffer #(.W(CNT_W), .RST_VAL(PER_DEFAULT)) u_per (
        .clk(clk), .rst(rst), .wr(per_wr), .din(per_in),
        .load(boundary), .staged(per_staged), .active(act_per)
    );

    bpwm_buffer #(.W(CNT_W), .RST_VAL(CMP_DEFAULT)) u_cmp (
        .clk(clk), .rst(rst), .wr(cmp_wr), .din(cmp_in),
        .load(boundary), .staged(cmp_staged), .active(act_cmp)
    );

    bpwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .restart(boundary), .count(cnt_q)
    );

    bpwm_phase #(.W(CNT_W)) u_phase (
        .clk(clk), .rst(rst), .boundary(boundary), .next_cmp(cmp_staged),
        .count(cnt_q), .act_cmp(act_cmp), .pwm(pwm_out),
        .strobe(frame_start), .holding(holding)
    );
endmodule

// File: rtl/bpwm_checks.sv
module bpwm_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input logic             frame_start,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_cmp
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pwm_out && !frame_start));

    p_strobe_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (cnt_q == '0));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_start && act_per != '0) |=> !frame_start);

    p_rise_at_start_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && act_cmp != '0) |-> pwm_out);

    p_low_at_match_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == act_cmp) |-> !pwm_out);

    p_zero_cmp_low_r4: assert property (@(posedge clk) disable iff (rst)
        (act_cmp == '0) |-> !pwm_out);

    p_full_on_r5: assert property (@(posedge clk) disable iff (rst)
        (act_cmp > act_per) |-> pwm_out);

    p_cmp_held_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(act_cmp));

    p_per_held_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(act_per));
endmodule

bind bpwm_top bpwm_checks #(.CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst(rst), .pwm_out(pwm_out), .frame_start(frame_start),
    .cnt_q(cnt_q), .act_per(act_per), .act_cmp(act_cmp)
);

// File: tb/bpwm_top_test.sv
module bpwm_top_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         per_wr = 1'b0, cmp_wr = 1'b0;
    logic [W-1:0] per_in = '0, cmp_in = '0;
    logic         pwm_out, frame_start;

    int n_chk = 0;
    int n_bad = 0;
    string focus = "";

    // reference state
    bit         m_hold, m_start;
    int         m_cnt, m_per, m_cmp, s_per, s_cmp;

    always #10 clk = ~clk;

    bpwm_top #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .per_wr(per_wr), .per_in(per_in),
        .cmp_wr(cmp_wr), .cmp_in(cmp_in), .pwm_out(pwm_out),
        .frame_start(frame_start)
    );

    function automatic bit exp_pwm();
        return !m_hold && (m_cnt < m_cmp);
    endfunction

    function automatic string pwm_tag();
        if (m_hold)            return "R1/R10";
        if (m_per == 0)        return "R8";
        if (m_cmp == 0)        return "R4";
        if (m_cmp > m_per)     return "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cnt=%0d per=%0d cmp=%0d)",
                     tag, focus, act, exp, m_cnt, m_per, m_cmp);
        end
    endtask

    // one clock: drive at negedge, update model after posedge, compare at next negedge
    task automatic tick(input bit r, input bit wp, input int p, input bit wc, input int c);
        rst = r; per_wr = wp; per_in = W'(p); cmp_wr = wc; cmp_in = W'(c);
        @(posedge clk);
        if (r) begin
            m_hold = 1; m_cnt = 0; m_per = (1 << W) - 1; m_cmp = 0;
            s_per = (1 << W) - 1; s_cmp = 0; m_start = 0;
        end else begin
            if (m_hold || m_cnt == m_per) begin
                m_cnt = 0; m_per = s_per; m_cmp = s_cmp; m_hold = 0; m_start = 1;
            end else begin
                m_cnt++; m_start = 0;
            end
            if (wp) s_per = p;
            if (wc) s_cmp = c;
        end
        @(negedge clk);
        check(r ? "R1" : pwm_tag(), pwm_out, r ? 1'b0 : exp_pwm());
        check(r ? "R1" : (m_per == 0 ? "R8" : "R2"), frame_start, r ? 1'b0 : m_start);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic to_last_count();
        while (m_hold || m_cnt != m_per) tick(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        focus = "R1 reset";
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0);
        // R10: program during hold, first period picks up staged values
        focus = "R10 first period";
        tick(0, 1, 9, 1, 4);
        idle(25);
        // R3 mid-range threshold, R7 period change mid-period
        focus = "R7 period write";
        idle(3);
        tick(0, 1, 5, 0, 0);
        idle(20);
        // R4 zero threshold
        focus = "R4 zero";
        tick(0, 0, 0, 1, 0);
        idle(15);
        // R5 threshold = P+1 and far above
        focus = "R5 full";
        tick(0, 0, 0, 1, 6);
        idle(15);
        tick(0, 0, 0, 1, 200);
        idle(15);
        // R6 write on the boundary edge itself
        focus = "R6 boundary write";
        tick(0, 0, 0, 1, 2);
        idle(10);
        to_last_count();
        tick(0, 0, 0, 1, 5);
        idle(15);
        // R9 several writes in one period
        focus = "R9 last wins";
        tick(0, 1, 11, 1, 1);
        tick(0, 1, 7, 1, 9);
        tick(0, 1, 8, 1, 3);
        idle(30);
        // R8 single-clock period
        focus = "R8 one clock";
        tick(0, 1, 0, 1, 0);
        idle(20);
        tick(0, 0, 0, 1, 1);
        idle(10);
        tick(0, 0, 0, 1, 0);
        idle(5);
        // reset in the middle of a run
        focus = "R1 mid reset";
        tick(0, 1, 6, 1, 3);
        idle(4);
        tick(1, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0);
        tick(0, 1, 4, 1, 2);
        idle(12);
        // random mix
        focus = "random";
        for (int i = 0; i < 4000; i++) begin
            bit wp = ($urandom_range(0, 9) == 0);
            bit wc = ($urandom_range(0, 5) == 0);
            tick(0, wp, $urandom_range(0, 15), wc, $urandom_range(0, 18));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule